// File: doc/BRIEF.md
# Two-Channel Down-Counting Event Timer

A register-mapped peripheral with two independent timer channels. Each channel divides the system clock by a programmable prescale factor and counts down from a software-written initial value. When the count runs out, the channel expires. In periodic mode it reloads and keeps running. In one-shot mode it halts and drops its own enable bit. Every expiry sets a per-channel flag in a shared status word. The channel's interrupt line is that flag gated by the channel's interrupt-enable bit.

Software drives the block through a single-cycle register port. A write is taken on the clock edge where `busWr` is high. Read data is combinational from the address. To arm a one-shot event, software writes the initial count while the channel is stopped and then sets the count-enable bit. To service an interrupt, software writes 1 to the channel's status bit.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads zero and both interrupt lines are low.
- R2: Word address map: channel c uses address 4c for control, 4c+1 for initial count and 4c+2 for the current count (read-only). The status word is at address 15.
- R3: Control word layout: bit 30 is count-enable, bit 29 is interrupt-enable, bits 28:27 are the mode (01 is periodic, any other value is one-shot) and bits 7:0 are the prescale P. Only these bits are stored; all other bits read back as zero.
- R4: While enabled, the count drops by one every P+1 clock edges.
- R5: If the count is 1 or 0 when a prescaled tick arrives, the channel expires, so a start from initial count N expires on the N*(P+1)-th edge after the enabling write. Expiry sets the channel's status flag.
- R6: In periodic mode, expiry reloads the initial count and counting continues.
- R7: In one-shot mode, expiry leaves the count at 0 and clears the count-enable bit.
- R8: Status bit c belongs to channel c. Writing 1 to a bit clears that flag, writing 0 leaves it unchanged, and writing 0x1F clears every flag.
- R9: A channel's interrupt line is high exactly when its flag and its interrupt-enable bit are both set. The flag still sets when the interrupt is disabled.
- R10: Writing zero to a control register stops the channel, freezes its count and drops its interrupt line.
- R11: A write to the initial count while the channel is stopped also loads the current count. While the channel runs, such a write leaves the current count alone and is only used at the next reload.
- R12: A control write that takes count-enable from 0 to 1 restarts the count from the initial value and restarts the prescale phase.
- R13: If a flag is cleared on the same edge on which its channel expires, the flag ends up set.
- R14: Reads of unused addresses return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Word address of the register access |
| busWr | input | 1 | Write strobe, taken on the rising clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irq | output | 2 | Per-channel interrupt request |

## Verification
A wrong prescale phase or count value appears at the current-count register within P+1 cycles of the fault. A late or early expiry appears one edge off in the status word and on `irq`. A wrong mode decision appears at the expiry edge: the count either returns to the initial value or stays at zero with the enable bit cleared. The narrowest window is the edge where a flag clear meets an expiry. A fault there flips the status bit on the very next read.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int DATA_W  = 32;
  localparam int EN_BIT  = 30;
  localparam int IE_BIT  = 29;
  localparam int MODE_HI = 28;
  localparam int MODE_LO = 27;
  localparam logic [1:0] MODE_PERIODIC = 2'b01;

  // strobes from register decode to one channel datapath
  typedef struct packed {
    logic ctrlWr;
    logic loadWr;
    logic flagClr;
  } chanStb_t;
endpackage

// File: rtl/tick_timer_chan.sv
module tick_timer_chan
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanStb_t          stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] ctrlWord,
  output logic [CNT_W-1:0]  loadVal,
  output logic [CNT_W-1:0]  countVal,
  output logic              flag,
  output logic              irq
);
  logic             running;
  logic             intEn;
  logic [1:0]       mode;
  logic [PRE_W-1:0] preLim;
  logic [PRE_W-1:0] preCnt;
  logic             tick;
  logic             expire;
  logic             periodic;

  assign periodic = (mode == MODE_PERIODIC);
  assign tick     = running && !stb.ctrlWr && (preCnt == preLim);
  assign expire   = tick && (countVal <= CNT_W'(1));
  assign irq      = flag && intEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      intEn    <= 1'b0;
      mode     <= '0;
      preLim   <= '0;
      preCnt   <= '0;
      loadVal  <= '0;
      countVal <= '0;
      flag     <= 1'b0;
    end else begin
      if (stb.ctrlWr) begin
        running <= wrData[EN_BIT];
        intEn   <= wrData[IE_BIT];
        mode    <= wrData[MODE_HI:MODE_LO];
        preLim  <= wrData[PRE_W-1:0];
        if (wrData[EN_BIT] && !running) begin
          countVal <= loadVal;
          preCnt   <= '0;
        end
      end else if (running) begin
        if (tick) begin
          preCnt <= '0;
          if (expire) begin
            if (periodic) begin
              countVal <= loadVal;
            end else begin
              countVal <= '0;
              running  <= 1'b0;
            end
          end else begin
            countVal <= countVal - CNT_W'(1);
          end
        end else begin
          preCnt <= preCnt + PRE_W'(1);
        end
      end
      if (stb.loadWr) begin
        loadVal <= wrData[CNT_W-1:0];
        if (!running) countVal <= wrData[CNT_W-1:0];
      end
      if (expire) flag <= 1'b1;
      else if (stb.flagClr) flag <= 1'b0;
    end
  end

  always_comb begin
    ctrlWord                  = '0;
    ctrlWord[EN_BIT]          = running;
    ctrlWord[IE_BIT]          = intEn;
    ctrlWord[MODE_HI:MODE_LO] = mode;
    ctrlWord[PRE_W-1:0]       = preLim;
  end
endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic                          busWr,
  input  logic [NUM_CH-1:0]             clrMask,
  input  logic [NUM_CH-1:0][DATA_W-1:0] ctrlWord,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  loadVal,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  countVal,
  input  logic [NUM_CH-1:0]             flags,
  output chanStb_t [NUM_CH-1:0]         stb,
  output logic [DATA_W-1:0]             busRdata
);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = {ADDR_W{1'b1}};

  logic statusWr;
  assign statusWr = busWr && (busAddr == STATUS_ADDR);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(4 * c);
    assign stb[c].ctrlWr  = busWr && (busAddr == BASE);
    assign stb[c].loadWr  = busWr && (busAddr == BASE + ADDR_W'(1));
    assign stb[c].flagClr = statusWr && clrMask[c];
  end

  always_comb begin
    busRdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (busAddr == ADDR_W'(4 * c))     busRdata = ctrlWord[c];
      if (busAddr == ADDR_W'(4 * c + 1)) busRdata = DATA_W'(loadVal[c]);
      if (busAddr == ADDR_W'(4 * c + 2)) busRdata = DATA_W'(countVal[c]);
    end
    if (busAddr == STATUS_ADDR) busRdata = DATA_W'(flags);
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] irq
);
  chanStb_t [NUM_CH-1:0]         stb;
  logic [NUM_CH-1:0][DATA_W-1:0] ctrlWord;
  logic [NUM_CH-1:0][CNT_W-1:0]  loadVal;
  logic [NUM_CH-1:0][CNT_W-1:0]  countVal;
  logic [NUM_CH-1:0]             flags;

  tick_timer_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs (
    .busAddr (busAddr),
    .busWr   (busWr),
    .clrMask (busWdata[NUM_CH-1:0]),
    .ctrlWord(ctrlWord),
    .loadVal (loadVal),
    .countVal(countVal),
    .flags   (flags),
    .stb     (stb),
    .busRdata(busRdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tick_timer_chan #(.CNT_W(CNT_W), .PRE_W(PRE_W)) chan (
      .clk     (clk),
      .rstN    (rstN),
      .stb     (stb[c]),
      .wrData  (busWdata),
      .ctrlWord(ctrlWord[c]),
      .loadVal (loadVal[c]),
      .countVal(countVal[c]),
      .flag    (flags[c]),
      .irq     (irq[c])
    );
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [ADDR_W-1:0]         busAddr,
  input logic                      busWr,
  input logic [31:0]               busWdata,
  input logic [NUM_CH-1:0]         irq,
  input logic [NUM_CH-1:0][31:0]   ctrlWord,
  input logic [NUM_CH-1:0][CNT_W-1:0] countVal,
  input logic [NUM_CH-1:0][CNT_W-1:0] loadVal,
  input logic [NUM_CH-1:0]         flags
);
  localparam logic [ADDR_W-1:0] STA = {ADDR_W{1'b1}};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(4 * c);
    localparam logic [ADDR_W-1:0] LA = ADDR_W'(4 * c + 1);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (flags[c] && !(busWr && busAddr == STA && busWdata[c])) |=> flags[c]);

    // R10
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && busAddr == CA && busWdata == 32'd0) |=> (!irq[c] && !ctrlWord[c][30]));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlWord[c][30] && !(busWr && busAddr == CA))
      |=> (countVal[c] == $past(countVal[c]) || countVal[c] == $past(countVal[c]) - CNT_W'(1)
           || countVal[c] == $past(loadVal[c]) || countVal[c] == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!ctrlWord[c][30] && !(busWr && (busAddr == CA || busAddr == LA)))
      |=> $stable(countVal[c]));
  end
endmodule

bind tick_timer tick_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWr   (busWr),
  .busWdata(busWdata),
  .irq     (irq),
  .ctrlWord(ctrlWord),
  .countVal(countVal),
  .loadVal (loadVal),
  .flags   (flags)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EN = 32'h4000_0000;
  localparam logic [31:0] IE = 32'h2000_0000;
  localparam logic [31:0] PER = 32'h0800_0000;
  localparam logic [3:0] STA = 4'hF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  tick_timer uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] expCount(int n, int p, int k, bit per);
    int t = k / (p + 1);
    if (per) return 32'(n - (t % n));
    return (t >= n) ? 32'd0 : 32'(n - t);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    idle(3);
    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      check("R1 reset read", v, 32'd0);
    end
    check("R1 reset irq", 32'(irq), 32'd0);
    rstN = 1'b1;
    idle(1);

    // R3 control field storage and mask
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd4, v);
    check("R3 ctrl readback mask", v, 32'h7800_00FF);
    wr(4'd4, 32'd0);
    rd(4'd4, v);
    check("R10 ctrl zero readback", v, 32'd0);

    // R14 unused addresses, R2 map
    wr(4'd1, 32'h0000_0055);
    wr(4'd3, 32'hDEAD_BEEF);
    wr(4'd8, 32'hDEAD_BEEF);
    rd(4'd3, v); check("R14 unused 3 read", v, 32'd0);
    rd(4'd8, v); check("R14 unused 8 read", v, 32'd0);
    rd(4'd1, v); check("R14 load0 untouched", v, 32'h55);
    rd(4'd2, v); check("R11 disabled load copies count", v, 32'h55);
    rd(4'd6, v); check("R2 ch1 count separate", v, 32'd0);

    // R11 load write while running, R6 reload uses it
    wr(4'd0, 32'd0);
    wr(4'd1, 32'd4);
    wr(STA, 32'h1F);
    wr(4'd0, EN | PER);          // E0
    idle(1);                     // E1 count 3
    wr(4'd1, 32'd10);            // E2 count 2
    rd(4'd2, v); check("R11 running load leaves count", v, 32'd2);
    idle(2);                     // E4 expire -> reload 10
    rd(4'd2, v); check("R6 periodic reload new value", v, 32'd10);
    rd(STA, v); check("R5 flag after expiry", v, 32'd1);
    check("R9 irq off when ie clear", 32'(irq), 32'd0);

    // R13 set wins over clear on expiry edge
    wr(4'd0, 32'd0);
    wr(4'd1, 32'd3);
    wr(STA, 32'h1F);
    rd(STA, v); check("R8 clear all", v, 32'd0);
    wr(4'd0, EN | PER);          // E0
    idle(2);                     // E1,E2
    wr(STA, 32'h1);              // E3 expiry and clear
    rd(STA, v); check("R13 set wins", v, 32'd1);
    wr(STA, 32'h2);              // E4 other bit only
    rd(STA, v); check("R8 write of other bit keeps flag", v, 32'd1);
    wr(STA, 32'h1);              // E5
    rd(STA, v); check("R8 write one clears", v, 32'd0);

    // R10 stop freezes count
    wr(4'd0, 32'd0);
    rd(4'd2, v);
    idle(5);
    begin
      logic [31:0] v2;
      rd(4'd2, v2);
      check("R10 count frozen", v2, v);
    end

    // R9 flag sets with ie low, irq follows ie
    wr(4'd5, 32'd2);
    wr(STA, 32'h1F);
    wr(4'd4, EN);                // one-shot, ie=0
    idle(2);
    rd(STA, v); check("R9 flag sets without ie", v, 32'd2);
    check("R9 irq low without ie", 32'(irq), 32'd0);
    rd(4'd4, v); check("R7 one-shot clears enable", v, 32'd0);
    rd(4'd6, v); check("R7 one-shot count zero", v, 32'd0);
    wr(4'd4, IE);
    check("R9 irq with ie", 32'(irq), 32'd2);
    wr(4'd4, 32'd0);
    check("R10 irq dropped by zero ctrl", 32'(irq), 32'd0);

    // R12 restart on enable, prescale phase reset
    wr(4'd5, 32'd5);
    wr(4'd4, EN | PER | 32'd2);  // E0
    idle(4);
    rd(4'd6, v); check("R4 prescaled count", v, 32'd4);
    wr(4'd4, 32'd0);
    wr(4'd4, EN | PER | 32'd2);  // restart E0
    rd(4'd6, v); check("R12 restart count", v, 32'd5);
    idle(2);
    rd(4'd6, v); check("R12 phase reset", v, 32'd5);
    idle(1);
    rd(4'd6, v); check("R12 first tick", v, 32'd4);
    wr(4'd4, 32'd0);

    // random runs
    for (int it = 0; it < 40; it++) begin
      int ch = int'($urandom_range(0, 1));
      int n = int'($urandom_range(1, 12));
      int p = int'($urandom_range(0, 3));
      bit per = 1'($urandom_range(0, 1));
      int k = int'($urandom_range(0, 60));
      int t;
      logic [3:0] base = 4'(4 * ch);
      wr(base + 4'd1, 32'(n));
      wr(STA, 32'h1F);
      wr(base, EN | IE | (per ? PER : 32'd0) | 32'(p));
      idle(k);
      t = k / (p + 1);
      rd(base + 4'd2, v);
      check(per ? "R6 random periodic count" : "R4 random one-shot count", v, expCount(n, p, k, per));
      rd(STA, v);
      check("R5 random flag", 32'(v[ch]), 32'(t >= n));
      check("R9 random irq", 32'(irq[ch]), 32'(t >= n));
      rd(base, v);
      check("R7 random enable state", 32'(v[30]), 32'(per || t < n));
      wr(base, 32'd0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule